// File: doc/BRIEF.md
# Sticky Status and Interrupt Controller

This block keeps a small set of sticky status bits that record supply and recovery events: power-on, two low-voltage detection levels and a self-recovery reset. It also derives five interrupt flags from them and from two timekeeping events, the alarm match and the countdown reaching zero. Each flag has its own enable. The interrupt request is the OR of the five flags and is brought out both active-high and active-low, ready to drive interrupt pins.

Software reaches the block through a one-cycle register write port. Writing 0 to a status or flag bit clears it. Writing 1 leaves it as it is. The enable register is overwritten as a whole. The voltage detectors, alarm comparator and countdown timer sit outside the block. The detectors supply levels, and the other sources supply one-cycle pulses.

The flags for low-voltage 1, low-voltage 2 and self-recovery are backed by their status bit. If software clears such a flag while the matching status bit is still set, the flag comes back one cycle later. It stays cleared only when software clears the flag first and then the status bit.

Top module: `stsirq_ctrl`

## Requirements
- R1: While rst_n is low and after its release, status_o is 4'b0001 (power-on set), flags_o and enables_o are 0, irq_o is 0 and irq_n_o is 1.
- R2: A one-cycle pulse on alarm_hit_i (flag bit 0) or timer_zero_i (flag bit 1) sets its flag at the next clock edge only if the matching enables_o bit is 1. With the enable at 0 the pulse leaves the flag at 0.
- R3: irq_o is 1 exactly when any flags_o bit is 1, and irq_n_o is always its complement.
- R4: Status bit 1 sets while vlow1_i is high, bit 2 sets while vlow2_i is high, and bit 3 sets on a recov_rst_i pulse. Each bit stays set after its cause goes away.
- R5: A write with wr_sel_i=0 clears every status bit whose wr_data_i bit (bits 3..0) is 0. No other action clears a status bit.
- R6: A write with wr_sel_i=1 clears every flag whose wr_data_i bit (bits 4..0) is 0.
- R7: Flags 2, 3 and 4 (low-voltage 1, low-voltage 2, self-recovery) set at the same edge as their status bit 1, 2 or 3 when enabled. If such a flag is cleared while its status bit stays set, it re-asserts one cycle later. Clearing the flag and then the status bit leaves both at 0.
- R8: Writing 1 to any status or flag bit leaves that bit unchanged.
- R9: If a set event and a clearing write hit the same status or flag bit in one cycle, the bit ends set.
- R10: A write with wr_sel_i=2 loads wr_data_i into enables_o (bit order as the flags). Clearing an enable does not clear a flag that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_hit_i | input | 1 | Alarm match pulse |
| timer_zero_i | input | 1 | Countdown reached zero pulse |
| vlow1_i | input | 1 | Low-voltage level 1 detector output |
| vlow2_i | input | 1 | Low-voltage level 2 detector output |
| recov_rst_i | input | 1 | Self-recovery reset pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Target: 0 status, 1 flags, 2 enables, 3 none |
| wr_data_i | input | 5 | Write data |
| status_o | output | 4 | Sticky status: 0 power-on, 1 vlow1, 2 vlow2, 3 recovery |
| flags_o | output | 5 | Flags: 0 alarm, 1 timer, 2 vlow1, 3 vlow2, 4 recovery |
| enables_o | output | 5 | Per-flag enables |
| irq_o | output | 1 | Combined request, active high |
| irq_n_o | output | 1 | Combined request, active low |

## Verification
Two things can land on the same bit in one cycle: a hardware set and a software clear. The bench provokes this by raising an alarm pulse, a recovery pulse or a held low-voltage level in the same cycle as a write of 0 to that bit. It then expects the bit to read 1 after the edge. A second overlap is a flag clear that meets a still-set status bit. Here the bench expects the flag to read 0 for one cycle and 1 on the next. The bench also runs the flag-then-status clear sequence and expects both bits to stay at 0.

// File: rtl/stsirq_pkg.sv
package stsirq_pkg;
  localparam int unsigned NUM_FLAGS = 5;
  localparam int unsigned NUM_STAT  = 4;
  localparam int unsigned WDATA_W   = NUM_FLAGS;

  // status bit positions
  localparam int unsigned ST_PON = 0;
  localparam int unsigned ST_V1  = 1;
  localparam int unsigned ST_V2  = 2;
  localparam int unsigned ST_SR  = 3;

  // flag bit positions
  localparam int unsigned FL_ALM = 0;
  localparam int unsigned FL_TMR = 1;
  localparam int unsigned FL_V1  = 2;
  localparam int unsigned FL_V2  = 3;
  localparam int unsigned FL_SR  = 4;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_FLAGS  = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/stsirq_sticky_reg.sv
// Bank of write-0-to-clear bits. set_i wins over a clear in the same
// cycle; hold_set_i re-arms a bit only when it is not being cleared.
module stsirq_sticky_reg #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] hold_set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  function automatic logic [W-1:0] sticky_next(
    input logic [W-1:0] q, input logic [W-1:0] s,
    input logic [W-1:0] h, input logic [W-1:0] c);
    return s | (~c & (q | h));
  endfunction

  logic [W-1:0] q_r;

  assign nxt_o = sticky_next(q_r, set_i, hold_set_i, clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) q_r <= RST_VAL;
    else        q_r <= nxt_o;
  end

  assign q_o = q_r;

  // R5 / R6: a set bit drops only when a clear hit it
  a_r5_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(q_o) & ~$past(clr_i)) & ~q_o) == '0));

  // R9: a set event always leaves the bit at 1
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_i) & ~q_o) == '0));

  // R8: a bit rises only from a set source, never from a write
  a_r8_no_write_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & ~$past(q_o) & ~$past(set_i | hold_set_i)) == '0));
endmodule

// File: rtl/stsirq_en_reg.sv
module stsirq_en_reg #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= data_i;
  end
endmodule

// File: rtl/stsirq_req_or.sv
module stsirq_req_or #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] flags_i,
  output logic         req_o,
  output logic         req_n_o
);
  function automatic logic any_set(input logic [W-1:0] v);
    logic r;
    r = 1'b0;
    for (int i = 0; i < W; i++) r = r | v[i];
    return r;
  endfunction

  assign req_o   = any_set(flags_i);
  assign req_n_o = ~req_o;
endmodule

// File: rtl/stsirq_ctrl.sv
module stsirq_ctrl
  import stsirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alarm_hit_i,
  input  logic                 timer_zero_i,
  input  logic                 vlow1_i,
  input  logic                 vlow2_i,
  input  logic                 recov_rst_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_sel_i,
  input  logic [WDATA_W-1:0]   wr_data_i,
  output logic [NUM_STAT-1:0]  status_o,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [NUM_FLAGS-1:0] enables_o,
  output logic                 irq_o,
  output logic                 irq_n_o
);
  localparam logic [NUM_STAT-1:0] STAT_RST = NUM_STAT'(1) << ST_PON;

  // named internal events
  logic                 wr_status, wr_flags, wr_enable;
  logic [NUM_STAT-1:0]  st_set, st_clr, st_q, st_nxt;
  logic [NUM_FLAGS-1:0] fl_set, fl_hold, fl_clr, fl_q, fl_nxt_unused;
  logic [NUM_FLAGS-1:0] en_q;

  function automatic logic [NUM_FLAGS-1:0] clear_mask(
    input logic hit, input logic [NUM_FLAGS-1:0] d);
    return hit ? ~d : '0;
  endfunction

  assign wr_status = wr_en_i && (wr_sel_i == SEL_STATUS);
  assign wr_flags  = wr_en_i && (wr_sel_i == SEL_FLAGS);
  assign wr_enable = wr_en_i && (wr_sel_i == SEL_ENABLE);

  // status events: power-on comes only from reset
  always_comb begin
    st_set         = '0;
    st_set[ST_V1]  = vlow1_i;
    st_set[ST_V2]  = vlow2_i;
    st_set[ST_SR]  = recov_rst_i;
  end
  assign st_clr = clear_mask(wr_status, wr_data_i)[NUM_STAT-1:0];

  stsirq_sticky_reg #(.W(NUM_STAT), .RST_VAL(STAT_RST)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (st_set),
    .hold_set_i ('0),
    .clr_i      (st_clr),
    .q_o        (st_q),
    .nxt_o      (st_nxt)
  );

  // flag events gated by enables; condition-backed flags also re-arm
  // from the next-state status so a status clear stops them at once
  always_comb begin
    fl_set          = '0;
    fl_set[FL_ALM]  = alarm_hit_i;
    fl_set[FL_TMR]  = timer_zero_i;
    fl_set[FL_V1]   = st_set[ST_V1];
    fl_set[FL_V2]   = st_set[ST_V2];
    fl_set[FL_SR]   = st_set[ST_SR];
    fl_set          = fl_set & en_q;
    fl_hold         = '0;
    fl_hold[FL_V1]  = st_nxt[ST_V1];
    fl_hold[FL_V2]  = st_nxt[ST_V2];
    fl_hold[FL_SR]  = st_nxt[ST_SR];
    fl_hold         = fl_hold & en_q;
  end
  assign fl_clr = clear_mask(wr_flags, wr_data_i);

  stsirq_sticky_reg #(.W(NUM_FLAGS), .RST_VAL('0)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (fl_set),
    .hold_set_i (fl_hold),
    .clr_i      (fl_clr),
    .q_o        (fl_q),
    .nxt_o      (fl_nxt_unused)
  );

  stsirq_en_reg #(.W(NUM_FLAGS)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (wr_enable),
    .data_i (wr_data_i),
    .q_o    (en_q)
  );

  stsirq_req_or #(.W(NUM_FLAGS)) u_or (
    .flags_i (fl_q),
    .req_o   (irq_o),
    .req_n_o (irq_n_o)
  );

  assign status_o  = st_q;
  assign flags_o   = fl_q;
  assign enables_o = en_q;

  // R2: alarm flag rises only from an enabled alarm pulse
  a_r2_alarm_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[FL_ALM]) |-> $past(enables_o[FL_ALM] && alarm_hit_i));

  // R7: a low-voltage-1 flag is never set without its status bit
  a_r7_v1_backed: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[FL_V1] && !$past(flags_o[FL_V1]) |-> status_o[ST_V1]);

  // R3: request pins are complementary
  a_r3_pins_complement: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o != irq_n_o);

  // R10: enables change only on an enable write
  a_r10_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable |=> $stable(enables_o));
endmodule

// File: tb/tb_stsirq_ctrl.sv
`timescale 1ns/1ps
module tb_stsirq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alarm_hit_i = 0, timer_zero_i = 0, vlow1_i = 0, vlow2_i = 0, recov_rst_i = 0;
  logic wr_en_i = 0;
  logic [1:0] wr_sel_i = 2'd3;
  logic [4:0] wr_data_i = '0;
  logic [3:0] status_o;
  logic [4:0] flags_o, enables_o;
  logic irq_o, irq_n_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stsirq_ctrl dut (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [4:0] d);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    tick();
    wr_en_i = 0; wr_sel_i = 2'd3;
  endtask

  task automatic t_reset();
    chk("R1 status", 5'(status_o), 5'b00001);
    chk("R1 flags", flags_o, 0);
    chk("R1 enables", enables_o, 0);
    chk("R1 irq", {3'b0, irq_o, irq_n_o}, 5'b00001);
  endtask

  task automatic t_enable();
    wr(2'd2, 5'b10110);
    chk("R10 enable load", enables_o, 5'b10110);
    wr(2'd2, 5'b11111);
    chk("R10 enable all", enables_o, 5'b11111);
  endtask

  task automatic t_alarm_timer();
    alarm_hit_i = 1; tick(); alarm_hit_i = 0;
    chk("R2 alarm set", flags_o, 5'b00001);
    chk("R3 irq on", {3'b0, irq_o, irq_n_o}, 5'b00010);
    timer_zero_i = 1; tick(); timer_zero_i = 0;
    chk("R2 timer set", flags_o, 5'b00011);
    wr(2'd1, 5'b11111);
    chk("R8 flag write ones", flags_o, 5'b00011);
    wr(2'd1, 5'b11110);
    chk("R6 clear alarm", flags_o, 5'b00010);
    wr(2'd1, 5'b00000);
    chk("R6 clear all", flags_o, 0);
    chk("R3 irq off", {3'b0, irq_o, irq_n_o}, 5'b00001);
  endtask

  task automatic t_disabled();
    wr(2'd2, 5'b11100);
    alarm_hit_i = 1; timer_zero_i = 1; tick(); alarm_hit_i = 0; timer_zero_i = 0;
    chk("R2 disabled pulses", flags_o, 0);
    wr(2'd2, 5'b11111);
    alarm_hit_i = 1; tick(); alarm_hit_i = 0;
    wr(2'd2, 5'b00000);
    chk("R10 flag kept after disable", flags_o, 5'b00001);
    chk("R3 irq kept", 5'(irq_o), 5'b00001);
    wr(2'd1, 5'b00000);
    wr(2'd2, 5'b11111);
  endtask

  task automatic t_status_lv1();
    wr(2'd0, 5'b01111);
    chk("R8 status write ones", 5'(status_o), 5'b00001);
    wr(2'd0, 5'b01110);
    chk("R5 clear power-on", 5'(status_o), 0);
    vlow1_i = 1; tick();
    chk("R4 vlow1 status", 5'(status_o), 5'b00010);
    chk("R7 vlow1 flag", flags_o, 5'b00100);
    vlow1_i = 0; tick();
    chk("R4 vlow1 sticky", 5'(status_o), 5'b00010);
    wr(2'd1, 5'b11011);
    chk("R7 flag cleared one cycle", flags_o, 0);
    tick();
    chk("R7 flag re-asserts", flags_o, 5'b00100);
    wr(2'd1, 5'b11011);
    wr(2'd0, 5'b01101);
    chk("R5 vlow1 status cleared", 5'(status_o), 0);
    tick();
    chk("R7 flag stays clear", flags_o, 0);
  endtask

  task automatic t_lv2_sr();
    vlow2_i = 1; tick(); vlow2_i = 0;
    recov_rst_i = 1; tick(); recov_rst_i = 0;
    chk("R4 vlow2+recovery status", 5'(status_o), 5'b01100);
    chk("R7 vlow2+recovery flags", flags_o, 5'b11000);
    tick(); tick();
    chk("R4 still sticky", 5'(status_o), 5'b01100);
    wr(2'd1, 5'b00111);
    wr(2'd0, 5'b00000);
    chk("R5 all status cleared", 5'(status_o), 0);
    tick();
    chk("R7 flags stay clear", flags_o, 0);
  endtask

  task automatic t_collide();
    alarm_hit_i = 1; wr(2'd1, 5'b00000); alarm_hit_i = 0;
    chk("R9 alarm set vs clear", flags_o, 5'b00001);
    recov_rst_i = 1; wr(2'd0, 5'b00000); recov_rst_i = 0;
    chk("R9 recovery set vs clear", 5'(status_o), 5'b01000);
    vlow1_i = 1; wr(2'd0, 5'b00000);
    chk("R9 vlow1 level vs clear", 5'(status_o), 5'b00010);
    vlow1_i = 0;
    wr(2'd1, 5'b00000);
    wr(2'd0, 5'b00000);
    wr(2'd1, 5'b00000);
    tick();
    chk("R6 final flags clear", flags_o, 0);
    chk("R5 final status clear", 5'(status_o), 0);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1; tick();
    t_reset();
    t_enable();
    t_alarm_timer();
    t_disabled();
    t_status_lv1();
    t_lv2_sr();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule